// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Per-Channel Pre-Dividers

This block drives four independent pulse-width modulated outputs from one input clock. Software configures it through a plain 32-bit register port with a write strobe and a combinational read. Each channel has a run bit, a 2-bit pre-divider select, a 16-bit period length and a 16-bit high-time count. The pre-divider slows the channel's step counter by 1, 8, 64 or 512. The period length counts pre-divided steps. The output is high for the first `duty` steps of every period.

Written values first go to programmed registers. A channel copies them into its working set only when one period ends and the next begins, so a period is never cut short or stretched. A stopped channel holds its step counter and pre-divider at zero and drives its output low. It starts a fresh period, with the latest programmed values, on the edge that sets its run bit.

Top module: `pwm_quad`

## Requirements
- R1: The control word is at byte address 0x00. Bit n (n = 0..3) is the run bit of channel n. Bits [4+2n+1:4+2n] are the pre-divider select of channel n. A read returns the last written run and select bits, and bits [31:12] read as zero.
- R2: Select code 0 divides by 1, code 1 by 8, code 2 by 64 and code 3 by 512. One step of the channel lasts that many clock cycles.
- R3: Channel n's setup word is at byte address 0x04 + 4n. The period length is in bits [15:0] and the high-time count is in bits [31:16], and a read returns the last written word. A period holds `length` steps, and a length of 0 means 65536 steps.
- R4: Within a period the output is high while the step index is below the high-time count and low afterwards. A high-time count at or above the period length gives a constant high output.
- R5: A high-time count of 0 gives a constant low output.
- R6: When its run bit is clear, a channel's output is low and its counters are held at zero. Setting the run bit starts a new period on that edge, with the output high in the following cycle if the high-time count is non-zero.
- R7: A write to a running channel's select, length or high-time count does not change the period in progress. It takes effect from the next period.
- R8: A write whose clock edge is the same edge that ends a period takes effect in the period that starts on that edge.
- R9: Reset clears every register to zero and drives every output low. A read from any address other than the five mapped words returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock shared by all channels |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_addr | input | AW (5) | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | NCH (4) | One modulated output per channel |

## Verification
The collision of interest is a register write landing on the exact edge where a channel wraps from its last step to step 0, so that the write into the programmed register and the copy into the working set happen together. The bench locks onto a rising output and counts clock cycles to the final step of the period. It then drives the write so that it lands on the wrapping edge. The period that starts on that edge must already show the new high time, and no stale period may appear. A second case writes one cycle after a period starts and expects the old high time to finish that period unchanged.

// File: rtl/pwm_quad.sv
module pwm_quad #(
  parameter int NCH   = 4,
  parameter int CNT_W = 16,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [NCH-1:0]   pwm_out
);
  localparam int SEL_W    = 2;
  localparam int SEL_LSB  = 4;
  localparam int DUTY_LSB = 16;
  localparam int STEP_LOG = 3;
  localparam int PD_W     = STEP_LOG * ((1 << SEL_W) - 1);

  logic [NCH-1:0]                 en_q;
  logic [NCH-1:0][SEL_W-1:0]      sel_q, act_sel_q, nxt_sel;
  logic [NCH-1:0][CNT_W-1:0]      tb_q, duty_q, nxt_tb, nxt_duty;
  logic [NCH-1:0][CNT_W-1:0]      act_tb_q, act_duty_q, cnt_q;
  logic [NCH-1:0][PD_W-1:0]       pd_q, pd_last;
  logic [NCH-1:0]                 cfg_wr, tick_w, wrap_w;

  wire ctrl_wr = bus_we && (bus_addr == '0);

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      cfg_wr[n]   = bus_we && (bus_addr == AW'(4 * (n + 1)));
      nxt_sel[n]  = ctrl_wr   ? bus_wdata[SEL_LSB + SEL_W*n +: SEL_W] : sel_q[n];
      nxt_tb[n]   = cfg_wr[n] ? bus_wdata[0 +: CNT_W]                : tb_q[n];
      nxt_duty[n] = cfg_wr[n] ? bus_wdata[DUTY_LSB +: CNT_W]         : duty_q[n];
      pd_last[n]  = PD_W'(((PD_W+1)'(1) << (STEP_LOG * act_sel_q[n])) - (PD_W+1)'(1));
      tick_w[n]   = (pd_q[n] == pd_last[n]);
      wrap_w[n]   = tick_w[n] && (cnt_q[n] == act_tb_q[n] - CNT_W'(1));
      pwm_out[n]  = en_q[n] && (cnt_q[n] < act_duty_q[n]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      sel_q  <= '0;
      tb_q   <= '0;
      duty_q <= '0;
    end else begin
      if (ctrl_wr) en_q <= bus_wdata[NCH-1:0];
      sel_q  <= nxt_sel;
      tb_q   <= nxt_tb;
      duty_q <= nxt_duty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q       <= '0;
      cnt_q      <= '0;
      act_sel_q  <= '0;
      act_tb_q   <= '0;
      act_duty_q <= '0;
    end else begin
      for (int n = 0; n < NCH; n++) begin
        if (!en_q[n]) begin
          pd_q[n]       <= '0;
          cnt_q[n]      <= '0;
          act_sel_q[n]  <= nxt_sel[n];
          act_tb_q[n]   <= nxt_tb[n];
          act_duty_q[n] <= nxt_duty[n];
        end else begin
          pd_q[n] <= tick_w[n] ? '0 : pd_q[n] + PD_W'(1);
          if (wrap_w[n]) begin
            cnt_q[n]      <= '0;
            act_sel_q[n]  <= nxt_sel[n];
            act_tb_q[n]   <= nxt_tb[n];
            act_duty_q[n] <= nxt_duty[n];
          end else if (tick_w[n]) begin
            cnt_q[n] <= cnt_q[n] + CNT_W'(1);
          end
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) begin
      bus_rdata[NCH-1:0] = en_q;
      for (int n = 0; n < NCH; n++)
        bus_rdata[SEL_LSB + SEL_W*n +: SEL_W] = sel_q[n];
    end
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == AW'(4 * (n + 1))) begin
        bus_rdata[0 +: CNT_W]        = tb_q[n];
        bus_rdata[DUTY_LSB +: CNT_W] = duty_q[n];
      end
    end
  end
endmodule

module pwm_quad_chk #(
  parameter int NCH   = 4,
  parameter int CNT_W = 16,
  parameter int AW    = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_we,
  input logic [AW-1:0]             bus_addr,
  input logic [NCH-1:0]            bus_wdata,
  input logic [NCH-1:0]            en_q,
  input logic [NCH-1:0]            wrap_w,
  input logic [NCH-1:0]            pwm_out,
  input logic [NCH-1:0][CNT_W-1:0] cnt_q,
  input logic [NCH-1:0][CNT_W-1:0] act_tb_q,
  input logic [NCH-1:0][CNT_W-1:0] act_duty_q
);
  a_r1_run_bits_written: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == '0) |=> (en_q == $past(bus_wdata)));

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    a_r6_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[n] |-> !pwm_out[n]);
    a_r6_restart_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q[n]) |-> (cnt_q[n] == '0));
    a_r5_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
      (act_duty_q[n] == '0) |-> !pwm_out[n]);
    a_r4_full_duty_high: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[n] && act_tb_q[n] != '0 && act_duty_q[n] >= act_tb_q[n]) |-> pwm_out[n]);
    a_r3_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[n] && act_tb_q[n] != '0) |-> (cnt_q[n] < act_tb_q[n]));
    a_r7_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_q[n]) && en_q[n] && !$past(wrap_w[n]))
        |-> ($stable(act_duty_q[n]) && $stable(act_tb_q[n])));
  end
endmodule

bind pwm_quad pwm_quad_chk #(.NCH(NCH), .CNT_W(CNT_W), .AW(AW)) u_pwm_quad_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata[NCH-1:0]),
  .en_q       (en_q),
  .wrap_w     (wrap_w),
  .pwm_out    (pwm_out),
  .cnt_q      (cnt_q),
  .act_tb_q   (act_tb_q),
  .act_duty_q (act_duty_q)
);

// File: tb/test_pwm_quad.sv
`timescale 1ns/1ps
module test_pwm_quad;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  pwm_quad i_pwm_quad (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #2.5 clk = ~clk;

  typedef struct { int ch; int hi; int per; string tag; } exp_t;
  exp_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ratio(input int sel);
    return 1 << (3 * sel);
  endfunction

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_addr = 5'(addr); bus_wdata = data; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(input int addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = 5'(addr);
    #1;
    check(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic wait_rise(input int ch);
    @(negedge clk);
    while (pwm_out[ch]) @(negedge clk);
    while (!pwm_out[ch]) @(negedge clk);
  endtask

  task automatic expect_wave(input int ch, input int sel, input int tb, input int duty, input string tag);
    exp_t e;
    int steps = (tb == 0) ? 65536 : tb;
    e.ch = ch; e.hi = duty * ratio(sel); e.per = steps * ratio(sel); e.tag = tag;
    sb.push_back(e);
    wait (sb.size() == 0);
  endtask

  task automatic hold_check(input int ch, input bit lvl, input int cycles, input string tag);
    int bad = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (pwm_out[ch] != lvl) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  initial begin : monitor
    forever begin
      exp_t e;
      int h, l;
      wait (sb.size() > 0);
      e = sb[0];
      wait_rise(e.ch);
      h = 0;
      while (pwm_out[e.ch]) begin h++; @(negedge clk); end
      l = 0;
      while (!pwm_out[e.ch]) begin l++; @(negedge clk); end
      check(h == e.hi, {e.tag, " high time"}, h, e.hi);
      check(h + l == e.per, {e.tag, " period"}, h + l, e.per);
      void'(sb.pop_front());
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : driver
    int h;
    repeat (4) @(negedge clk);
    // R9 reset state
    check(pwm_out == 4'h0, "R9 outputs after reset", pwm_out, 0);
    rd_check(5'h00, 32'h0, "R9 control after reset");
    rd_check(5'h04, 32'h0, "R9 setup ch0 after reset");
    rd_check(5'h10, 32'h0, "R9 setup ch3 after reset");
    @(negedge clk); rst_n = 1'b1;

    // R3 setup words and readback
    wr(5'h04, {16'd3, 16'd10});
    wr(5'h08, {16'd2, 16'd5});
    wr(5'h0C, {16'd1, 16'd4});
    wr(5'h10, {16'd1, 16'd2});
    rd_check(5'h04, {16'd3, 16'd10}, "R3 setup ch0 readback");
    rd_check(5'h10, {16'd1, 16'd2}, "R3 setup ch3 readback");
    check(pwm_out == 4'h0, "R6 outputs low before run", pwm_out, 0);

    // R1 run bits with selects ch0=0 ch1=1 ch2=2 ch3=3, upper bits dropped
    wr(5'h00, 32'hFFFF_FE4F);
    rd_check(5'h00, 32'h0000_0E4F, "R1 control readback");
    rd_check(5'h14, 32'h0, "R9 unmapped read");
    rd_check(5'h05, 32'h0, "R9 misaligned read");

    // R2 / R4 waveforms for each select code
    expect_wave(0, 0, 10, 3, "R4 ch0 div1");
    expect_wave(1, 1, 5, 2, "R2 ch1 div8");
    expect_wave(2, 2, 4, 1, "R2 ch2 div64");
    expect_wave(3, 3, 2, 1, "R2 ch3 div512");

    // R7 write one edge into a period: old period completes unchanged
    wait_rise(0);
    bus_addr = 5'h04; bus_wdata = {16'd8, 16'd10}; bus_we = 1'b1;
    h = 0;
    while (pwm_out[0]) begin
      h++; @(negedge clk);
      if (h == 1) bus_we = 1'b0;
    end
    check(h == 3, "R7 period in progress keeps old high time", h, 3);
    expect_wave(0, 0, 10, 8, "R7 new high time next period");

    // R8 write on the wrapping edge
    wait_rise(0);
    repeat (9) @(negedge clk);
    bus_addr = 5'h04; bus_wdata = {16'd5, 16'd10}; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    h = 0;
    while (pwm_out[0]) begin h++; @(negedge clk); end
    check(h == 5, "R8 write on boundary used at once", h, 5);
    expect_wave(0, 0, 10, 5, "R8 following period");

    // R5 zero high time
    wr(5'h08, {16'd0, 16'd5});
    repeat (100) @(negedge clk);
    hold_check(1, 1'b0, 120, "R5 zero high time stays low");

    // R4 high time equal to length
    wr(5'h0C, {16'd4, 16'd4});
    repeat (600) @(negedge clk);
    hold_check(2, 1'b1, 600, "R4 full high time stays high");

    // R6 stop and restart
    wr(5'h00, 32'h0000_0E4E);
    check(pwm_out[0] == 1'b0, "R6 output low after stop", pwm_out[0], 0);
    hold_check(0, 1'b0, 30, "R6 stays low while stopped");
    wr(5'h00, 32'h0000_0E4F);
    h = 0;
    while (pwm_out[0]) begin h++; @(negedge clk); end
    check(h == 5, "R6 restart begins a fresh period", h, 5);
    expect_wave(0, 0, 10, 5, "R6 after restart");

    // R3 length 0 means 65536 steps, select change R7 at boundary
    wr(5'h10, {16'd1, 16'd0});
    wr(5'h00, 32'h0000_024F);
    rd_check(5'h00, 32'h0000_024F, "R1 select readback");
    expect_wave(3, 0, 0, 1, "R3 length zero");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule